// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Detector

This block turns two current-sense indications into latched fault flags. The fast level is a single-bit flag from an external analog comparator. It is brought into the clock domain through a flop chain and then sets the primary fault. The same comparator level is also passed straight to a routing output, so it can drive a general-purpose pin with no clocked delay.

The slower level works on 8-bit current-sense ADC results. Each result that arrives with its valid strobe is compared against a programmable threshold byte. A 2-bit delay select sets how many over-threshold results in a row must be seen before the secondary fault is raised. One enable bit arms both faults. Clearing it drops both flags and restarts qualification.

Conversions of any other kind, such as a supply-side voltage reading, are kept away from this block by holding the valid strobe low. Cycles without the strobe never affect a fault.

Top module: `dual_overcurrent_guard`

## Requirements
- R1: While reset is asserted, `fault_primary` and `fault_secondary` are both 0.
- R2: With `fault_en` high, `cmp_in` is passed through a two-flop synchronizer. A high level driven just after rising edge N sets `fault_primary` at rising edge N+3 and not before.
- R3: `ovc_route` equals `cmp_in` in the same cycle, without a clock. It is independent of `fault_en`, of the ADC samples and of `fault_secondary`.
- R4: A sample counts as over threshold only when `adc_data` is strictly greater than `sec_limit`, compared as unsigned numbers. A sample equal to the threshold is not over.
- R5: `qual_sel` sets how many consecutive over-threshold valid samples are needed: 00 needs 1, 01 needs 2, 10 needs 4 and 11 needs 8. `fault_secondary` rises at the rising edge that captures the last sample of that run.
- R6: A valid sample at or below `sec_limit` resets the count of consecutive over-threshold samples to zero.
- R7: Cycles with `adc_valid` low neither advance nor reset the consecutive-sample count.
- R8: Both fault outputs are sticky. Once set, they stay high while `fault_en` stays high, whatever the inputs do.
- R9: At the first rising edge with `fault_en` low, both faults clear and the sample count resets. While `fault_en` is low, no input can set either fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_in | input | 1 | Asynchronous primary comparator level, high means overcurrent |
| adc_data | input | 8 | Current-sense ADC result |
| adc_valid | input | 1 | High for one cycle per current-sense result |
| sec_limit | input | 8 | Secondary overcurrent threshold |
| qual_sel | input | 2 | Qualification length select (1, 2, 4 or 8 samples) |
| fault_en | input | 1 | Arms both current faults; low clears them |
| fault_primary | output | 1 | Sticky primary overcurrent fault |
| fault_secondary | output | 1 | Sticky secondary overcurrent fault |
| ovc_route | output | 1 | Direct copy of the comparator level, for pin routing |

## Verification
The assertions assume that `sec_limit` and `qual_sel` are held steady while a qualification run is in progress. They also assume that `adc_data` is meaningful only in cycles where `adc_valid` is high. The stimulus changes threshold and delay select only while `fault_en` is low, and it drives every input on the falling clock edge. With 8-bit data and a 2-bit select, the bench sweeps every select value against run lengths of 0 to 9 samples. It also places data one below, equal to and one above a set of thresholds that includes both ends of the range.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

   // number of consecutive over-threshold samples demanded by a select code
   function automatic int unsigned qual_len(input int unsigned sel);
      return 32'd1 << sel;
   endfunction

   // largest run length reachable with a select field of the given width
   function automatic int unsigned max_len(input int unsigned sel_w);
      return 32'd1 << ((32'd1 << sel_w) - 1);
   endfunction

endpackage

// File: rtl/ocg_sync.sv
module ocg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ocg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ocg_qualifier.sv
module ocg_qualifier
   import ocg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DATA_W-1:0] sample,
   input  logic              sample_valid,
   input  logic [DATA_W-1:0] limit,
   input  logic [SEL_W-1:0]  sel,
   output logic              hit
);
   localparam int MAX_LEN = int'(max_len(SEL_W));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   if (DATA_W < 1) begin : g_bad_data
      $error("ocg_qualifier: DATA_W must be positive");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("ocg_qualifier: SEL_W must be 1 to 3");
   end

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_inc;
   logic [CNT_W-1:0] need;
   logic             over;

   assign over    = sample > limit;
   assign need    = CNT_W'(1) << sel;
   assign run_inc = (run_cnt == CNT_W'(MAX_LEN)) ? run_cnt : run_cnt + CNT_W'(1);
   assign hit     = enable && sample_valid && over && (run_inc >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cnt <= '0;
      else if (!enable)        run_cnt <= '0;
      else if (sample_valid)   run_cnt <= over ? run_inc : '0;
   end
endmodule

// File: rtl/ocg_sticky.sv
module ocg_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic set,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (!enable) q <= 1'b0;
      else if (set)     q <= 1'b1;
   end
endmodule

// File: rtl/dual_overcurrent_guard.sv
module dual_overcurrent_guard #(
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit ROUTE_SYNCED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_in,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_valid,
   input  logic [DATA_W-1:0] sec_limit,
   input  logic [SEL_W-1:0]  qual_sel,
   input  logic              fault_en,
   output logic              fault_primary,
   output logic              fault_secondary,
   output logic              ovc_route
);
   logic cmp_sync;
   logic sec_hit;

   ocg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_in),
      .q     (cmp_sync)
   );

   ocg_qualifier #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (fault_en),
      .sample       (adc_data),
      .sample_valid (adc_valid),
      .limit        (sec_limit),
      .sel          (qual_sel),
      .hit          (sec_hit)
   );

   ocg_sticky u_pri_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (fault_en),
      .set    (cmp_sync),
      .q      (fault_primary)
   );

   ocg_sticky u_sec_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (fault_en),
      .set    (sec_hit),
      .q      (fault_secondary)
   );

   if (ROUTE_SYNCED) begin : g_route_sync
      assign ovc_route = cmp_sync;
   end else begin : g_route_raw
      assign ovc_route = cmp_in;
   end
endmodule

// File: rtl/ocg_checker.sv
module ocg_checker #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_in,
   input logic [DATA_W-1:0] adc_data,
   input logic              adc_valid,
   input logic [DATA_W-1:0] sec_limit,
   input logic [SEL_W-1:0]  qual_sel,
   input logic              fault_en,
   input logic              fault_primary,
   input logic              fault_secondary
);
   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (!fault_primary && !fault_secondary);
      end
   end

   assert_primary_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_primary) |-> $past(cmp_in, 2));

   assert_strictly_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_secondary) |-> $past(adc_valid && fault_en && (adc_data > sec_limit)));

   assert_single_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_en && adc_valid && (adc_data > sec_limit) && qual_sel == '0) |=> fault_secondary);

   assert_pri_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_primary && fault_en) |=> fault_primary);

   assert_sec_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_secondary && fault_en) |=> fault_secondary);

   assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_en |=> (!fault_primary && !fault_secondary));
endmodule

bind dual_overcurrent_guard ocg_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .cmp_in          (cmp_in),
   .adc_data        (adc_data),
   .adc_valid       (adc_valid),
   .sec_limit       (sec_limit),
   .qual_sel        (qual_sel),
   .fault_en        (fault_en),
   .fault_primary   (fault_primary),
   .fault_secondary (fault_secondary)
);

// File: tb/dual_overcurrent_guard_test.sv
`timescale 1ns/1ps
module dual_overcurrent_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_in = 1'b0;
   logic [7:0] adc_data = '0;
   logic       adc_valid = 1'b0;
   logic [7:0] sec_limit = '0;
   logic [1:0] qual_sel = '0;
   logic       fault_en = 1'b0;
   logic       fault_primary;
   logic       fault_secondary;
   logic       ovc_route;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dual_overcurrent_guard uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmp_in          (cmp_in),
      .adc_data        (adc_data),
      .adc_valid       (adc_valid),
      .sec_limit       (sec_limit),
      .qual_sel        (qual_sel),
      .fault_en        (fault_en),
      .fault_primary   (fault_primary),
      .fault_secondary (fault_secondary),
      .ovc_route       (ovc_route)
   );

   task automatic check(input logic actual, input logic expected, input string tag);
      n_checks++;
      if (actual !== expected) begin
         n_errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, actual, expected, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // drives one valid sample; returns after the capturing edge
   task automatic send_sample(input logic [7:0] d);
      @(negedge clk);
      adc_data  = d;
      adc_valid = 1'b1;
      @(negedge clk);
      adc_valid = 1'b0;
   endtask

   // disables for one edge, checks the clear, re-arms
   task automatic rearm();
      @(negedge clk);
      fault_en = 1'b0;
      @(negedge clk);
      check(fault_primary, 1'b0, "R9 primary cleared");
      check(fault_secondary, 1'b0, "R9 secondary cleared");
      fault_en = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      check(fault_primary, 1'b0, "R1 primary in reset");
      check(fault_secondary, 1'b0, "R1 secondary in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R3: route follows comparator with no clock, enable low
      for (int i = 0; i < 4; i++) begin
         cmp_in = i[0];
         #0.5;
         check(ovc_route, i[0], "R3 route mirrors cmp, disabled");
         @(negedge clk);
      end
      // R9: comparator high while disabled never sets fault
      cmp_in = 1'b1;
      repeat (5) @(negedge clk);
      check(fault_primary, 1'b0, "R9 no primary while disabled");
      cmp_in = 1'b0;
      sec_limit = 8'd10;
      send_sample(8'd200);
      check(fault_secondary, 1'b0, "R9 no secondary while disabled");
      repeat (3) @(negedge clk);

      // R2: synchronizer latency
      fault_en = 1'b1;
      @(negedge clk);
      cmp_in = 1'b1;
      @(negedge clk);
      check(fault_primary, 1'b0, "R2 primary after 1 edge");
      @(negedge clk);
      check(fault_primary, 1'b0, "R2 primary after 2 edges");
      @(negedge clk);
      check(fault_primary, 1'b1, "R2 primary after 3 edges");
      check(fault_secondary, 1'b0, "R2 secondary untouched by cmp");
      cmp_in = 1'b0;
      repeat (6) @(negedge clk);
      check(fault_primary, 1'b1, "R8 primary sticky");
      rearm();

      // R4: threshold boundary sweep, single-sample qualification
      qual_sel = 2'd0;
      foreach (sec_limit_set[j]) begin
         for (int d = sec_limit_set[j] - 1; d <= sec_limit_set[j] + 1; d++) begin
            if (d >= 0 && d <= 255) begin
               @(negedge clk);
               fault_en = 1'b0;
               sec_limit = sec_limit_set[j][7:0];
               @(negedge clk);
               fault_en = 1'b1;
               send_sample(d[7:0]);
               check(fault_secondary, (d > sec_limit_set[j]), "R4 strictly greater");
            end
         end
      end

      // R5: every select against run lengths 0..9
      for (int s = 0; s < 4; s++) begin
         for (int len = 0; len < 10; len++) begin
            @(negedge clk);
            fault_en = 1'b0;
            qual_sel = s[1:0];
            sec_limit = 8'd100;
            @(negedge clk);
            fault_en = 1'b1;
            for (int k = 1; k <= len; k++) begin
               send_sample(8'd101 + 8'(k % 50));
               check(fault_secondary, (k >= (1 << s)), "R5 run length vs select");
            end
            send_sample(8'd100);
            check(fault_secondary, (len >= (1 << s)), "R8 secondary sticky after low sample");
            check(fault_primary, 1'b0, "R5 primary untouched by adc");
         end
      end

      // R6: a low sample restarts the run
      for (int s = 1; s < 4; s++) begin
         rearm();
         qual_sel = s[1:0];
         for (int k = 1; k < (1 << s); k++) send_sample(8'd150);
         send_sample(8'd100);
         for (int k = 1; k < (1 << s); k++) send_sample(8'd150);
         check(fault_secondary, 1'b0, "R6 low sample resets run");
         send_sample(8'd150);
         check(fault_secondary, 1'b1, "R6 run completes after restart");
      end

      // R7: idle cycles do not break or reset the run
      rearm();
      qual_sel = 2'd2;
      for (int k = 0; k < 4; k++) begin
         send_sample(8'd180);
         adc_data = 8'd0;
         repeat (3) @(negedge clk);
         check(fault_secondary, (k == 3), "R7 gaps without valid ignored");
      end
      // R3: route still mirrors comparator with secondary fault high
      cmp_in = 1'b1;
      #0.5;
      check(ovc_route, 1'b1, "R3 route high with secondary set");
      cmp_in = 1'b0;
      #0.5;
      check(ovc_route, 1'b0, "R3 route low with secondary set");
      rearm();

      repeat (2) @(negedge clk);
      finish_run();
   end

   int sec_limit_set [5] = '{0, 1, 127, 254, 255};
endmodule